// File: doc/BRIEF.md
# Addressed Serial Control Register Loader

This block receives 8-bit control words over three asynchronous lines (a serial clock, a data line and a strobe) and stores each word's payload in one of eight small control registers. A word is sent least significant bit first. Each bit is captured on a rising edge of the serial clock. A rising edge on the strobe commits the word. The three low bits of the word pick the register and the five high bits are stored. The block samples all external lines with its own system clock, which runs at 32 MHz or faster. Each line passes through a two-flop synchronizer, and edges are found from the synchronized values.

Every committed write gives a single-cycle, one-hot pulse that marks the register just written. All registers are presented on one flat bus for the motor-control logic that follows. The block also holds two fields of the focus stepper register and two of the zoom stepper register for deferred use. Rotation direction and excitation mode are stored at the strobe but are passed on only at the next rising edge of that stepper's own step clock.

Top module: `serial_reg_loader`

## Requirements
- R1: A word is sent as bits D0..D7, one bit per rising serial-clock edge, D0 first. The register index is D0 + 2·D1 + 4·D2. The stored payload has bit i equal to D(3+i), so payload bit 0 is D3 and payload bit 4 is D7.
- R2: A rising strobe edge that follows exactly eight accepted bits writes the payload into the addressed register. The same edge makes `wr_pulse` high on only the addressed bit, for exactly one system-clock cycle.
- R3: Rising serial-clock edges that occur while the strobe is high are neither shifted nor counted.
- R4: Every rising strobe edge clears the bit counter. A word with fewer or more than eight accepted bits is dropped: no register changes and no pulse is produced. The next well-formed word is then received normally.
- R5: A write changes only the addressed register. All other registers keep their values.
- R6: After reset, every register, both applied stepper outputs and `wr_pulse` are zero.
- R7: `foc_applied` is {payload bit 1 (excitation mode), payload bit 0 (direction)} of register 0. It takes a new value only on a synchronized rising edge of `foc_step`, and never at the strobe.
- R8: `zoom_applied` is the same pair of bits from register 1. It takes a new value only on a synchronized rising edge of `zoom_step`, and does not respond to `foc_step`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 32 MHz |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_clk | input | 1 | Serial bit clock, asynchronous |
| ser_dat | input | 1 | Serial data, asynchronous |
| ser_stb | input | 1 | Word strobe, asynchronous |
| foc_step | input | 1 | Focus stepper step clock, asynchronous |
| zoom_step | input | 1 | Zoom stepper step clock, asynchronous |
| reg_bank | output | 40 | All registers; register n is at bits [5n+4:5n] |
| wr_pulse | output | 8 | One-cycle one-hot write marker |
| foc_applied | output | 2 | Applied focus {mode, direction} |
| zoom_applied | output | 2 | Applied zoom {mode, direction} |

## Verification
The bench sends words of seven and nine bits. A loader that did not check the count would store a shifted payload at the wrong index, and the unexpected pulse would be caught by the scoreboard. The bench also toggles the serial clock while the strobe is high. A design that counted those edges would drop the next word or misalign it. Each write is compared against a model of the whole bank, so a mistake in the bit order or the address decode appears as the wrong register or wrong bits being written. The applied stepper outputs are read after the strobe and again after a step edge on each stepper clock. This shows when a design applies the settings at the strobe, or when it lets one stepper's clock update the other stepper.

// File: rtl/serial_reg_loader.sv
module serial_reg_loader #(
  parameter int ADDR_W    = 3,
  parameter int DATA_W    = 5,
  parameter int FOC_ADDR  = 0,
  parameter int ZOOM_ADDR = 1
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              ser_clk,
  input  logic                              ser_dat,
  input  logic                              ser_stb,
  input  logic                              foc_step,
  input  logic                              zoom_step,
  output logic [(1<<ADDR_W)*DATA_W-1:0]     reg_bank,
  output logic [(1<<ADDR_W)-1:0]            wr_pulse,
  output logic [1:0]                        foc_applied,
  output logic [1:0]                        zoom_applied
);
  localparam int NREG    = 1 << ADDR_W;
  localparam int FRAME_W = ADDR_W + DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_W + 1);

  logic [2:0] sck_q, stb_q, foc_q, zoom_q;
  logic [1:0] dat_q;
  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0]   bit_cnt;
  logic [DATA_W-1:0]  bank [NREG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_q <= '0; stb_q <= '0; foc_q <= '0; zoom_q <= '0; dat_q <= '0;
    end else begin
      sck_q  <= {sck_q[1:0], ser_clk};
      stb_q  <= {stb_q[1:0], ser_stb};
      foc_q  <= {foc_q[1:0], foc_step};
      zoom_q <= {zoom_q[1:0], zoom_step};
      dat_q  <= {dat_q[0], ser_dat};
    end
  end

  wire sck_rise  = sck_q[1] & ~sck_q[2] & ~stb_q[1];
  wire stb_rise  = stb_q[1] & ~stb_q[2];
  wire foc_rise  = foc_q[1] & ~foc_q[2];
  wire zoom_rise = zoom_q[1] & ~zoom_q[2];

  wire [ADDR_W-1:0] wr_addr = shreg[ADDR_W-1:0];
  wire [DATA_W-1:0] wr_data = shreg[FRAME_W-1:ADDR_W];
  wire              commit  = stb_rise && (bit_cnt == CNT_FULL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg   <= '0;
      bit_cnt <= '0;
    end else if (stb_rise) begin
      bit_cnt <= '0;
    end else if (sck_rise) begin
      shreg <= {dat_q[1], shreg[FRAME_W-1:1]};
      if (bit_cnt != CNT_OVER) bit_cnt <= bit_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) bank[i] <= '0;
      wr_pulse <= '0;
    end else begin
      wr_pulse <= '0;
      if (commit) begin
        bank[wr_addr]     <= wr_data;
        wr_pulse[wr_addr] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      foc_applied  <= '0;
      zoom_applied <= '0;
    end else begin
      if (foc_rise)  foc_applied  <= bank[FOC_ADDR][1:0];
      if (zoom_rise) zoom_applied <= bank[ZOOM_ADDR][1:0];
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign reg_bank[g*DATA_W +: DATA_W] = bank[g];
  end

  p_onehot_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_pulse));
  p_single_cycle_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pulse != '0) |=> (wr_pulse == '0));
  p_full_frame_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pulse != '0) |-> ($past(bit_cnt) == CNT_FULL));
  p_bank_moves_on_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(reg_bank) |-> (wr_pulse != '0));
  p_foc_on_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(foc_applied) |-> $past(foc_rise));
  p_zoom_on_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(zoom_applied) |-> $past(zoom_rise));
  p_no_shift_strobe_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stb_q[1]) && !$past(stb_rise) |-> $stable(shreg));
endmodule

// File: tb/sim_serial_reg_loader.sv
module sim_serial_reg_loader;
  localparam int HP = 20;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ser_clk = 0, ser_dat = 0, ser_stb = 0, foc_step = 0, zoom_step = 0;
  logic [39:0] reg_bank;
  logic [7:0]  wr_pulse;
  logic [1:0]  foc_applied, zoom_applied;

  always #5 clk = ~clk;

  serial_reg_loader u0 (.clk, .rst_n, .ser_clk, .ser_dat, .ser_stb, .foc_step,
    .zoom_step, .reg_bank, .wr_pulse, .foc_applied, .zoom_applied);

  int errs = 0, checks = 0;
  bit done = 0;
  logic [7:0] q_exp [$];
  logic [4:0] model [8];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  function automatic logic [39:0] model_flat();
    logic [39:0] f;
    for (int i = 0; i < 8; i++) f[i*5 +: 5] = model[i];
    return f;
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic send_bits(input logic [15:0] bits, input int n);
    for (int i = 0; i < n; i++) begin
      ser_dat = bits[i];
      wait_clk(HP); ser_clk = 1;
      wait_clk(HP); ser_clk = 0;
    end
  endtask

  task automatic strobe(input int extra_clks);
    wait_clk(HP); ser_stb = 1;
    for (int i = 0; i < extra_clks; i++) begin
      wait_clk(HP); ser_clk = 1;
      wait_clk(HP); ser_clk = 0;
    end
    wait_clk(HP); ser_stb = 0;
    wait_clk(HP);
  endtask

  task automatic write_reg(input logic [2:0] a, input logic [4:0] d, input int extra);
    q_exp.push_back({d, a});
    model[a] = d;
    send_bits({8'h00, d, a}, 8);
    strobe(extra);
    @(negedge clk);
    chk(reg_bank == model_flat(), "R5", reg_bank, model_flat());
  endtask

  task automatic step(input bit zoom);
    if (zoom) zoom_step = 1; else foc_step = 1;
    wait_clk(10);
    if (zoom) zoom_step = 0; else foc_step = 0;
    wait_clk(10);
    @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && wr_pulse != 0) begin
      if (q_exp.size() == 0) begin
        chk(0, "R4", wr_pulse, 0);
      end else begin
        logic [7:0] e;
        e = q_exp.pop_front();
        chk(wr_pulse == (8'd1 << e[2:0]), "R2", wr_pulse, 8'd1 << e[2:0]);
        chk(reg_bank[e[2:0]*5 +: 5] == e[7:3], "R1", reg_bank[e[2:0]*5 +: 5], e[7:3]);
      end
    end
  end

  initial begin
    wait_clk(200000);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    for (int i = 0; i < 8; i++) model[i] = '0;
    wait_clk(4); rst_n = 1; @(negedge clk);
    // R6 reset state
    chk(reg_bank == 0, "R6", reg_bank, 0);
    chk(wr_pulse == 0, "R6", wr_pulse, 0);
    chk({foc_applied, zoom_applied} == 0, "R6", {foc_applied, zoom_applied}, 0);

    // R7 deferred focus settings
    write_reg(3'd0, 5'b10111, 0);
    chk(foc_applied == 2'b00, "R7", foc_applied, 2'b00);
    step(0);
    chk(foc_applied == 2'b11, "R7", foc_applied, 2'b11);
    chk(zoom_applied == 2'b00, "R8", zoom_applied, 2'b00);

    // R1 R5 different addresses and patterns
    write_reg(3'd4, 5'b01101, 0);
    write_reg(3'd5, 5'b10010, 0);
    write_reg(3'd7, 5'b11111, 0);
    write_reg(3'd2, 5'b00001, 0);

    // R8 deferred zoom settings
    write_reg(3'd1, 5'b00001, 0);
    chk(zoom_applied == 2'b00, "R8", zoom_applied, 2'b00);
    step(0);
    chk(zoom_applied == 2'b00, "R8", zoom_applied, 2'b00);
    step(1);
    chk(zoom_applied == 2'b01, "R8", zoom_applied, 2'b01);
    chk(foc_applied == 2'b11, "R7", foc_applied, 2'b11);

    // R4 short and long frames are dropped
    send_bits(16'h005A, 7); strobe(0); @(negedge clk);
    chk(reg_bank == model_flat(), "R4", reg_bank, model_flat());
    send_bits(16'h01F3, 9); strobe(0); @(negedge clk);
    chk(reg_bank == model_flat(), "R4", reg_bank, model_flat());
    write_reg(3'd6, 5'b01010, 0);

    // R3 serial clocks during strobe high are ignored
    write_reg(3'd3, 5'b11001, 3);
    write_reg(3'd4, 5'b00110, 0);
    write_reg(3'd0, 5'b00010, 2);
    step(0);
    chk(foc_applied == 2'b10, "R7", foc_applied, 2'b10);

    wait_clk(5);
    chk(q_exp.size() == 0, "R2", q_exp.size(), 0);
    finish_run();
  end
endmodule